// File: doc/BRIEF.md
# Frame Pulse Clock Generator

This block turns one fast master clock into three output pairs. Each pair is a clock and a frame pulse. Every frame pulse marks the same 8 kHz frame boundary, and every output clock is a power-of-two division of the master clock. A free-running frame counter of 8192 master cycles drives all three pairs. With a 65.536 MHz master, the available output rates are 4.096, 8.192, 16.384 and 32.768 MHz.

Each pair has three control bits. A rate bit picks one of two clock periods for that pair. A clock-invert bit flips the clock, and a pulse-invert bit flips the frame pulse. The frame pulse is normally active low. It lasts one period of its own pair's clock and is centred on the frame boundary.

Control bits are taken in once per frame, 16 master cycles before the boundary. A change made during a frame therefore first shows up around the next boundary, and a clean period grid is kept. After reset, all outputs stay idle until the first time the control bits are taken in.

Top module: `fp_clkgen`

## Requirements
- R1: While reset is high, and after its release until the first take-in point, every clock output is 0 and every frame pulse output is 1, whatever the control inputs are.
- R2: The frame counter runs from 0 to 8191 and wraps to 0, so each frame pulse repeats every 8192 master cycles. Output values are registered: the outputs seen after the k-th rising edge following reset release reflect count value (k-1) mod 8192.
- R3: Pair 0 (`rate_hi_i[0]`): a value of 0 gives a clock period of 16 master cycles, and 1 gives 8 master cycles.
- R4: Pair 1 (`rate_hi_i[1]`): a value of 0 gives a clock period of 4 master cycles, and 1 gives 8 master cycles.
- R5: Pair 2 (`rate_hi_i[2]`): a value of 0 gives a clock period of 2 master cycles, and 1 gives 4 master cycles.
- R6: Let P be a pair's period. With its invert bit 0, the clock is 0 where (count mod P) < P/2 and 1 otherwise. The clock is therefore low just after the frame boundary at count 0.
- R7: With its invert bit 0, a pair's frame pulse is 0 for count values 8192-P/2 to 8191 and 0 to P/2-1, which is P cycles centred on the boundary. It is 1 at all other counts.
- R8: `clk_inv_i[k]` inverts the clock of pair k, and `fp_inv_i[k]` inverts its frame pulse. The two bits act independently of each other.
- R9: All control bits are sampled only on the edge where the count is 8176 (16 cycles before the boundary). Changes at other times have no effect on the outputs until the following outputs reflect count 8177.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_hi_i | input | 3 | Per-pair rate select, bit k for pair k |
| clk_inv_i | input | 3 | Per-pair clock inversion |
| fp_inv_i | input | 3 | Per-pair frame pulse inversion |
| clk_o | output | 3 | Output clocks, bit k for pair k |
| fp_n_o | output | 3 | Output frame pulses, active low when not inverted |

## Verification
The hardest situation to reach from the ports is a control change that lands in the middle of a frame and must be ignored until the take-in point. Two further tricky cases are the cycle where old settings hand over to new ones, and a frame pulse that straddles the wrap. The block exposes no count, so the stimulus counts master edges from reset release. It changes the inputs at chosen count values: several times inside one frame, just before and just after the take-in point, and across boundaries. Every cycle is compared with a model built from the requirements, which switches its own settings only at count 8176.

// File: rtl/fp_clkgen_pkg.sv
package fp_clkgen_pkg;

    localparam int NUM_PAIRS    = 3;
    localparam int FRAME_CYCLES = 8192;
    // log2 of the slowest clock period any pair can select
    localparam int MAX_DIV_LOG2 = 4;

    typedef struct packed {
        logic rate_hi;
        logic clk_inv;
        logic fp_inv;
    } pair_cfg_t;

    typedef struct packed {
        logic clk;
        logic fp_n;
    } pair_out_t;

    // log2 of the clock period, in master cycles, for a pair and its rate bit
    function automatic int div_log2(input int pair, input logic rate_hi);
        case (pair)
            0:       return rate_hi ? 3 : 4;
            1:       return rate_hi ? 3 : 2;
            default: return rate_hi ? 2 : 1;
        endcase
    endfunction

endpackage

// File: rtl/fp_clkgen_counter.sv
module fp_clkgen_counter #(
    parameter int FRAME_LEN = 8192,
    parameter int LATCH_AT  = 8176,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             latch_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LATCH_CNT = CNT_W'(LATCH_AT);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
            if (cnt_q == LATCH_CNT) armed_q <= 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign latch_o = (cnt_q == LATCH_CNT);
    assign armed_o = armed_q;

    // frame length: the last count is always followed by zero
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST_CNT) |=> (cnt_q == '0));

    // once running, the outputs never go back to idle without reset
    assert_armed_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q);

endmodule

// File: rtl/fp_clkgen_pair.sv
module fp_clkgen_pair
    import fp_clkgen_pkg::*;
#(
    parameter int PAIR_IDX  = 0,
    parameter int FRAME_LEN = 8192,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             latch_i,
    input  logic             armed_i,
    input  pair_cfg_t        cfg_i,
    output logic             clk_o,
    output logic             fp_n_o
);

    pair_cfg_t act_q;
    pair_out_t nxt;
    pair_out_t out_q;
    int        lg;
    int        half;
    int        cnt_ext;
    logic      phase_hi;
    logic      fp_window;

    // settings only move at the take-in point
    always_ff @(posedge clk) begin
        if (rst)          act_q <= '0;
        else if (latch_i) act_q <= cfg_i;
    end

    always_comb begin
        lg        = div_log2(PAIR_IDX, act_q.rate_hi);
        half      = 1 << (lg - 1);
        cnt_ext   = int'(cnt_i);
        phase_hi  = ((cnt_ext >> (lg - 1)) & 1) != 0;
        fp_window = (cnt_ext < half) || (cnt_ext >= FRAME_LEN - half);
        if (armed_i) begin
            nxt.clk  = phase_hi ^ act_q.clk_inv;
            nxt.fp_n = ~fp_window ^ act_q.fp_inv;
        end else begin
            nxt.clk  = 1'b0;
            nxt.fp_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '{clk: 1'b0, fp_n: 1'b1};
        else     out_q <= nxt;
    end

    assign clk_o  = out_q.clk;
    assign fp_n_o = out_q.fp_n;

    assert_idle_until_armed_R1: assert property (@(posedge clk) disable iff (rst)
        !armed_i |-> (clk_o == 1'b0 && fp_n_o == 1'b1));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !latch_i |=> $stable(act_q));

    assert_fp_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_i && cnt_i == '0) |=> (fp_n_o == act_q.fp_inv));

    assert_clk_low_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        (armed_i && cnt_i == '0) |=> (clk_o == act_q.clk_inv));

endmodule

// File: rtl/fp_clkgen.sv
module fp_clkgen
    import fp_clkgen_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_CYCLES,
    parameter int NPAIR     = NUM_PAIRS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPAIR-1:0] rate_hi_i,
    input  logic [NPAIR-1:0] clk_inv_i,
    input  logic [NPAIR-1:0] fp_inv_i,
    output logic [NPAIR-1:0] clk_o,
    output logic [NPAIR-1:0] fp_n_o
);

    localparam int CNT_W    = $clog2(FRAME_LEN);
    localparam int LATCH_AT = FRAME_LEN - (1 << MAX_DIV_LOG2);

    logic [CNT_W-1:0] cnt;
    logic             latch;
    logic             armed;

    fp_clkgen_counter #(
        .FRAME_LEN (FRAME_LEN),
        .LATCH_AT  (LATCH_AT),
        .CNT_W     (CNT_W)
    ) counter_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_o   (cnt),
        .latch_o (latch),
        .armed_o (armed)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        pair_cfg_t cfg;
        assign cfg = '{rate_hi: rate_hi_i[g], clk_inv: clk_inv_i[g], fp_inv: fp_inv_i[g]};

        fp_clkgen_pair #(
            .PAIR_IDX  (g),
            .FRAME_LEN (FRAME_LEN),
            .CNT_W     (CNT_W)
        ) pair_i (
            .clk     (clk),
            .rst     (rst),
            .cnt_i   (cnt),
            .latch_i (latch),
            .armed_i (armed),
            .cfg_i   (cfg),
            .clk_o   (clk_o[g]),
            .fp_n_o  (fp_n_o[g])
        );
    end

endmodule

// File: tb/fp_clkgen_tb_top.sv
module fp_clkgen_tb_top;

    localparam int FRAME = 8192;
    localparam int LATCH = 8176;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] rate_hi_i = '0;
    logic [2:0] clk_inv_i = '0;
    logic [2:0] fp_inv_i  = '0;
    logic [2:0] clk_o;
    logic [2:0] fp_n_o;

    int vectors  = 0;
    int failures = 0;
    int n_edges  = 0;

    // bench copy of the settings in force, per requirement R9
    logic [2:0] m_hi = '0, m_ci = '0, m_fi = '0;
    logic       m_armed = 1'b0;

    always #4 clk = ~clk;

    fp_clkgen dut_i (
        .clk       (clk),
        .rst       (rst),
        .rate_hi_i (rate_hi_i),
        .clk_inv_i (clk_inv_i),
        .fp_inv_i  (fp_inv_i),
        .clk_o     (clk_o),
        .fp_n_o    (fp_n_o)
    );

    // expected {clk, fp_n} from R1..R8
    function automatic logic [1:0] expect_pair(input int p, input logic hi, input logic ci,
                                               input logic fi, input logic armed, input int v);
        int period;
        logic ck, win;
        if (!armed) return 2'b01;
        if (p == 0)      period = hi ? 8 : 16;   // R3
        else if (p == 1) period = hi ? 8 : 4;    // R4
        else             period = hi ? 4 : 2;    // R5
        ck  = (v % period) >= period / 2;        // R6
        win = (v < period / 2) || (v >= FRAME - period / 2); // R7
        return {ck ^ ci, ~win ^ fi};             // R8
    endfunction

    task automatic step(input string tag);
        int v;
        logic [1:0] e;
        @(posedge clk);
        n_edges++;
        @(negedge clk);
        v = (n_edges - 1) % FRAME;               // R2
        for (int p = 0; p < 3; p++) begin
            e = expect_pair(p, m_hi[p], m_ci[p], m_fi[p], m_armed, v);
            vectors += 2;
            if (clk_o[p] !== e[1]) begin
                failures++;
                $display("FAIL %s pair%0d clk count %0d: got %b expected %b", tag, p, v, clk_o[p], e[1]);
            end
            if (fp_n_o[p] !== e[0]) begin
                failures++;
                $display("FAIL %s pair%0d fp count %0d: got %b expected %b", tag, p, v, fp_n_o[p], e[0]);
            end
        end
        if (v == LATCH) begin                    // R9: take-in edge was the one just passed
            m_hi = rate_hi_i; m_ci = clk_inv_i; m_fi = fp_inv_i; m_armed = 1'b1;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic t_reset_idle();
        rst = 1'b1;
        rate_hi_i = '1; clk_inv_i = '1; fp_inv_i = '1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vectors++;
            if (clk_o !== 3'b000 || fp_n_o !== 3'b111) begin
                failures++;
                $display("FAIL R1 in reset: got clk=%b fp=%b expected clk=000 fp=111", clk_o, fp_n_o);
            end
        end
        rate_hi_i = '0; clk_inv_i = '0; fp_inv_i = '0;
        rst = 1'b0;
        n_edges = 0;
        run(FRAME, "R1 R2 first frame");
    endtask

    task automatic t_slow_rates();
        run(FRAME, "R3 R4 R5 R6 R7 slow");
    endtask

    task automatic t_fast_rates();
        rate_hi_i = 3'b111;
        run(2 * FRAME, "R3 R4 R5 R9 fast");
        rate_hi_i = 3'b010;
        run(FRAME, "R3 R4 R5 mixed");
    endtask

    task automatic t_polarity();
        clk_inv_i = 3'b101;
        fp_inv_i  = 3'b011;
        run(2 * FRAME, "R8 polarity");
    endtask

    task automatic t_midframe();
        run(3000, "R9 before change");
        rate_hi_i = 3'b101; clk_inv_i = 3'b010; fp_inv_i = 3'b100;
        run(2000, "R9 first change ignored");
        rate_hi_i = 3'b011; clk_inv_i = 3'b111; fp_inv_i = 3'b000;
        run(LATCH - 5000 - 1, "R9 second change ignored");
        rate_hi_i = 3'b100; clk_inv_i = 3'b001; fp_inv_i = 3'b110;
        run(3, "R9 final value at take-in");
        rate_hi_i = 3'b000; clk_inv_i = 3'b000; fp_inv_i = 3'b000;
        run(FRAME + 100, "R9 after take-in");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got no completion, expected finish before limit");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_slow_rates();
        t_fast_rates();
        t_polarity();
        t_midframe();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule